// File: doc/BRIEF.md
# Processor Timer Bank with User Counter Mode

This block holds a parameterised number of per-processor timers and the mode register that controls them. Each timer has a four-word register window. A separate system window holds only the mode register. Each bit of the mode register sets the personality of one timer.

With its mode bit clear, a timer is an interval timer. It counts timebase ticks, compares the count against a programmed limit, and raises that processor's interrupt when the limit is met. A limit of zero makes it free-run with no match. With its mode bit set, the same registers become the two halves of a 54-bit tick counter. That counter is started and stopped by software and never interrupts.

Count values are presented in a fixed-point form in which one tick is worth 512, so the low nine bits of every count word read as zero. The timebase comes in on `tick`, one pulse per count step. Register accesses are single-cycle strobes: write data is taken at the clock edge, and read data is combinational from the current state.

Top module: `proc_timer_bank`

## Requirements
- R1: After reset every mode bit is 0, every timer runs in free-run interval mode with limit 0 and count 0, and no interrupt is raised.
- R2: In interval mode with a nonzero limit L (held in write-data bits 30:9 of word 0), the count steps once per tick. On the tick where the count would become L, the count returns to 0, the reached flag (bit 31 of word 1) sets, and the interrupt rises.
- R3: In interval mode, reading word 0 returns the limit and clears both reached and the interrupt. Writing word 0 sets the limit, zeroes the count and lowers the interrupt. Writing word 2 sets the limit and leaves the count running.
- R4: The mode register is word 4 of the system window (window select 0). Bit i selects user mode for timer i. Bits at or above the timer count are ignored and read as zero. A word-4 write through a processor window changes nothing.
- R5: A 0-to-1 mode change lowers that timer's interrupt, stops it, and clears its count and reached flag.
- R6: In user mode, word 0 reads {reached, count[53:23]} and word 1 reads {count[22:0], nine zero bits}.
- R7: In user mode, a write to word 0 replaces count[53:23] with write-data bits 30:0, and a write to word 1 replaces count[22:0] with write-data bits 31:9. Either write clears reached.
- R8: In user mode, writing bit 0 of word 3 starts the counter when it is 1 and stops it when it is 0, and writing the current state changes nothing. In interval mode, writes to word 3 are ignored.
- R9: A timer in user mode never raises its interrupt.
- R10: A 1-to-0 mode change restarts the timer in interval mode from count 0 with its running flag set, and the limit it held before is kept.
- R11: Word 3 reads the running flag in bit 0 of a processor window. It reads zero in the system window, and any window select above the timer count reads zero.
- R12: With limit 0, interval mode wraps the 22-bit count without setting reached or raising the interrupt.
- R13: In user mode, a tick at the all-ones 54-bit count wraps it to zero and sets reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one count step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| win_sel | input | WIN_W | Window: 0 system, i+1 processor timer i |
| reg_addr | input | 3 | Word index within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| irq | output | N_PROC | Per-processor interrupt lines |

## Verification
The hardest state to reach is the 54-bit user counter's wrap at the all-ones count. Plain ticking would need about 2^54 steps to get there. The stimulus instead loads both halves with all-ones through the user-mode word writes, starts the counter, and applies a single tick. It then reads back the cleared count and the set reached flag.

A second hard case is a mode switch while an interrupt is pending. The bench first drives a timer to its limit, then flips its mode bit through the system window in the following cycle. A behavioural reference model runs alongside the design and checks every clock.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   // one tick is worth 2**TICK_SH in the register view
   localparam int TICK_SH  = 9;
   localparam int LO_W     = 32 - TICK_SH;     // count bits in the low word
   localparam int HI_W     = 31;               // count bits in the high word
   localparam int CNT_W    = LO_W + HI_W;      // user counter width
   localparam int LIM_W    = 31 - TICK_SH;     // interval limit width
   localparam int MAX_PROC = 16;

   typedef enum logic [2:0] {
      REG_HI   = 3'd0,   // limit, or upper count half
      REG_LO   = 3'd1,   // count, or lower count half
      REG_KEEP = 3'd2,   // limit without count reset
      REG_STAT = 3'd3,   // running flag
      REG_MODE = 3'd4    // mode bits, system window only
   } ptb_reg_e;
endpackage

// File: rtl/ptb_decode.sv
module ptb_decode
   import ptb_pkg::*;
#(
   parameter int N_PROC = 4,
   parameter int WIN_W  = 3
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WIN_W-1:0]  win_sel,
   input  logic [2:0]        reg_addr,
   output logic              sys_sel,
   output logic              mode_wr,
   output logic [N_PROC-1:0] proc_sel,
   output logic [N_PROC-1:0] wr_hi,
   output logic [N_PROC-1:0] wr_lo,
   output logic [N_PROC-1:0] wr_keep,
   output logic [N_PROC-1:0] wr_stat,
   output logic [N_PROC-1:0] rd_hi
);
   assign sys_sel = (win_sel == '0);
   assign mode_wr = wr_en && sys_sel && (reg_addr == REG_MODE);

   for (genvar i = 0; i < N_PROC; i++) begin : g_win
      assign proc_sel[i] = (win_sel == WIN_W'(i + 1));
      assign wr_hi[i]    = wr_en && proc_sel[i] && (reg_addr == REG_HI);
      assign wr_lo[i]    = wr_en && proc_sel[i] && (reg_addr == REG_LO);
      assign wr_keep[i]  = wr_en && proc_sel[i] && (reg_addr == REG_KEEP);
      assign wr_stat[i]  = wr_en && proc_sel[i] && (reg_addr == REG_STAT);
      assign rd_hi[i]    = rd_en && proc_sel[i] && (reg_addr == REG_HI);
   end
endmodule

// File: rtl/ptb_mode.sv
module ptb_mode #(
   parameter int N_PROC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [N_PROC-1:0] mode_wdata,
   output logic [N_PROC-1:0] mode,
   output logic [N_PROC-1:0] to_user,
   output logic [N_PROC-1:0] to_limit
);
   // a change of a bit produces a one-cycle side-effect pulse for that timer
   always_comb begin
      to_user  = mode_wr ? (mode_wdata & ~mode) : '0;
      to_limit = mode_wr ? (~mode_wdata & mode) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode <= '0;
      else if (mode_wr) mode <= mode_wdata;
   end

   p_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (mode == $past(mode_wdata)));
   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode));
endmodule

// File: rtl/ptb_unit.sv
module ptb_unit
   import ptb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        user_mode,
   input  logic        to_user,
   input  logic        to_limit,
   input  logic        wr_hi,
   input  logic        wr_lo,
   input  logic        wr_keep,
   input  logic        wr_stat,
   input  logic        rd_hi,
   input  logic [31:0] wdata,
   input  logic [2:0]  raddr,
   output logic [31:0] rdata,
   output logic        irq
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt;
   logic [LIM_W-1:0] lim;
   logic             reached;
   logic             running;
   logic             irq_q;
   logic [LIM_W-1:0] lim_nxt;
   logic             lim_hit;
   logic             unused_wbits;

   assign unused_wbits = ^wdata[TICK_SH-1:1];
   assign lim_nxt      = cnt[LIM_W-1:0] + 1'b1;
   assign lim_hit      = (lim != '0) && (lim_nxt == lim);
   assign irq          = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         lim     <= '0;
         reached <= 1'b0;
         running <= 1'b1;
         irq_q   <= 1'b0;
      end else if (to_user) begin
         cnt     <= '0;
         reached <= 1'b0;
         running <= 1'b0;
         irq_q   <= 1'b0;
      end else if (to_limit) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (user_mode) begin
         irq_q <= 1'b0;
         if (wr_hi) begin
            cnt[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
            reached           <= 1'b0;
         end else if (wr_lo) begin
            cnt[LO_W-1:0] <= wdata[31:TICK_SH];
            reached       <= 1'b0;
         end else if (running && tick) begin
            if (cnt == CNT_MAX) begin
               cnt     <= '0;
               reached <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (wr_stat) running <= wdata[0];
      end else begin
         if (wr_hi) begin
            lim   <= wdata[30:TICK_SH];
            cnt   <= '0;
            irq_q <= 1'b0;
         end else begin
            if (wr_keep) lim <= wdata[30:TICK_SH];
            if (rd_hi) begin
               reached <= 1'b0;
               irq_q   <= 1'b0;
            end
            if (tick) begin
               if (lim_hit) begin
                  cnt     <= '0;
                  reached <= 1'b1;
                  irq_q   <= 1'b1;
               end else begin
                  cnt <= {{(CNT_W - LIM_W){1'b0}}, lim_nxt};
               end
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (raddr)
         REG_HI:   rdata = user_mode ? {reached, cnt[CNT_W-1:LO_W]}
                                     : {1'b0, lim, {TICK_SH{1'b0}}};
         REG_LO:   rdata = user_mode ? {cnt[LO_W-1:0], {TICK_SH{1'b0}}}
                                     : {reached, cnt[LIM_W-1:0], {TICK_SH{1'b0}}};
         REG_STAT: rdata = {31'b0, running};
         default:  rdata = '0;
      endcase
   end

   p_user_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> !irq);
   p_enter_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
      to_user |=> (!running && !irq && cnt == '0));
   p_leave_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
      to_limit |=> (running && cnt == '0));
   p_limit_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !user_mode |-> running);
   p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && !wr_stat && !to_user && !to_limit) |=> $stable(running));
endmodule

// File: rtl/proc_timer_bank.sv
module proc_timer_bank
   import ptb_pkg::*;
#(
   parameter  int N_PROC = 4,
   localparam int WIN_W  = $clog2(N_PROC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WIN_W-1:0]  win_sel,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [N_PROC-1:0] irq
);
   if (N_PROC < 1 || N_PROC > MAX_PROC) begin : g_bad_cfg
      $error("proc_timer_bank: N_PROC must lie in 1..16");
   end

   logic              sys_sel;
   logic              mode_wr;
   logic [N_PROC-1:0] proc_sel;
   logic [N_PROC-1:0] wr_hi, wr_lo, wr_keep, wr_stat, rd_hi;
   logic [N_PROC-1:0] mode, to_user, to_limit;
   logic [31:0]       unit_rd [N_PROC];

   ptb_decode #(.N_PROC(N_PROC), .WIN_W(WIN_W)) u_dec (
      .wr_en(wr_en), .rd_en(rd_en), .win_sel(win_sel), .reg_addr(reg_addr),
      .sys_sel(sys_sel), .mode_wr(mode_wr), .proc_sel(proc_sel),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_keep(wr_keep), .wr_stat(wr_stat),
      .rd_hi(rd_hi)
   );

   ptb_mode #(.N_PROC(N_PROC)) u_mode (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
      .mode_wdata(wdata[N_PROC-1:0]),
      .mode(mode), .to_user(to_user), .to_limit(to_limit)
   );

   for (genvar i = 0; i < N_PROC; i++) begin : g_unit
      ptb_unit u_unit (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .user_mode(mode[i]), .to_user(to_user[i]), .to_limit(to_limit[i]),
         .wr_hi(wr_hi[i]), .wr_lo(wr_lo[i]), .wr_keep(wr_keep[i]),
         .wr_stat(wr_stat[i]), .rd_hi(rd_hi[i]),
         .wdata(wdata), .raddr(reg_addr),
         .rdata(unit_rd[i]), .irq(irq[i])
      );
   end

   always_comb begin
      rdata = '0;
      if (sys_sel && reg_addr == REG_MODE) rdata = 32'(mode);
      for (int i = 0; i < N_PROC; i++) begin
         if (proc_sel[i]) rdata = unit_rd[i];
      end
   end

   p_mode_proc_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sys_sel) |=> $stable(mode));
   p_lo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_addr == REG_LO) |-> (rdata[TICK_SH-1:0] == '0));
   p_user_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & mode) == '0);
endmodule

// File: tb/proc_timer_bank_tb.sv
`timescale 1ns/1ps
module proc_timer_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  win = 3'd0, addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   proc_timer_bank #(.N_PROC(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .win_sel(win), .reg_addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // reference model
   logic [63:0] m_cnt [4];
   logic [21:0] m_lim [4];
   logic [21:0] m_old, m_nxt;
   logic [3:0]  m_reach, m_irq, m_run, m_mode;
   logic        m_nb, m_tu, m_tl, m_sel, m_mwr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 64'd0;
            m_lim[i] = 22'd0;
         end
         m_reach = 4'd0; m_irq = 4'd0; m_run = 4'hF; m_mode = 4'd0;
      end else begin
         m_mwr = wr_en && win == 3'd0 && addr == 3'd4;
         for (int i = 0; i < 4; i++) begin
            m_nb  = m_mwr ? wdata[i] : m_mode[i];
            m_tu  = m_mwr && m_nb && !m_mode[i];
            m_tl  = m_mwr && !m_nb && m_mode[i];
            m_sel = (win == 3'(i + 1));
            if (m_tu) begin
               m_cnt[i] = 64'd0; m_reach[i] = 0; m_run[i] = 0; m_irq[i] = 0;
            end else if (m_tl) begin
               m_cnt[i] = 64'd0; m_run[i] = 1;
            end else if (m_mode[i]) begin
               m_irq[i] = 0;
               if (m_sel && wr_en && addr == 3'd0) begin
                  m_cnt[i] = {10'd0, wdata[30:0], m_cnt[i][22:0]};
                  m_reach[i] = 0;
               end else if (m_sel && wr_en && addr == 3'd1) begin
                  m_cnt[i] = {m_cnt[i][63:23], wdata[31:9]};
                  m_reach[i] = 0;
               end else if (m_run[i] && tick) begin
                  if (m_cnt[i] == 64'h003F_FFFF_FFFF_FFFF) begin
                     m_cnt[i] = 64'd0; m_reach[i] = 1;
                  end else m_cnt[i] = m_cnt[i] + 64'd1;
               end
               if (m_sel && wr_en && addr == 3'd3) m_run[i] = wdata[0];
            end else begin
               if (m_sel && wr_en && addr == 3'd0) begin
                  m_lim[i] = wdata[30:9]; m_cnt[i] = 64'd0; m_irq[i] = 0;
               end else begin
                  m_old = m_lim[i];
                  if (m_sel && wr_en && addr == 3'd2) m_lim[i] = wdata[30:9];
                  if (m_sel && rd_en && addr == 3'd0) begin
                     m_reach[i] = 0; m_irq[i] = 0;
                  end
                  if (tick) begin
                     m_nxt = m_cnt[i][21:0] + 22'd1;
                     if (m_old != 22'd0 && m_nxt == m_old) begin
                        m_cnt[i] = 64'd0; m_reach[i] = 1; m_irq[i] = 1;
                     end else m_cnt[i] = {42'd0, m_nxt};
                  end
               end
            end
            m_mode[i] = m_nb;
         end
      end
   end

   function automatic logic [31:0] m_read(input int w, input int a);
      int i;
      if (w == 0) return (a == 4) ? {28'd0, m_mode} : 32'd0;
      if (w > 4) return 32'd0;
      i = w - 1;
      case (a)
         0: return m_mode[i] ? {m_reach[i], m_cnt[i][53:23]} : {1'b0, m_lim[i], 9'd0};
         1: return m_mode[i] ? {m_cnt[i][22:0], 9'd0} : {m_reach[i], m_cnt[i][21:0], 9'd0};
         3: return {31'd0, m_run[i]};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model comparison on every clock (R2 R9 R12 via irq, R6 R11 via rdata)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 irq vs model", {28'd0, irq}, {28'd0, m_irq});
         if (rd_en) chk("R6 rdata vs model", rdata, m_read(int'(win), int'(addr)));
      end
   end

   task automatic step(input logic t, input logic w, input logic r,
                       input logic [2:0] wi, input logic [2:0] ad, input logic [31:0] d);
      @(posedge clk); #2;
      tick = t; wr_en = w; rd_en = r; win = wi; addr = ad; wdata = d;
   endtask

   task automatic wr(input logic [2:0] wi, input logic [2:0] ad, input logic [31:0] d);
      step(0, 1, 0, wi, ad, d);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) step(1, 0, 0, 3'd0, 3'd0, 32'd0);
   endtask

   task automatic rd(input logic [2:0] wi, input logic [2:0] ad,
                     input logic [31:0] exp, input string tag);
      step(0, 0, 1, wi, ad, 32'd0);
      @(negedge clk);
      chk(tag, rdata, exp);
   endtask

   task automatic irq_is(input logic [3:0] exp, input string tag);
      step(0, 0, 0, 3'd0, 3'd0, 32'd0);
      @(negedge clk);
      chk(tag, {28'd0, irq}, {28'd0, exp});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      rd(3'd1, 3'd3, 32'd1, "R1 status after reset");
      rd(3'd0, 3'd4, 32'd0, "R1 mode after reset");
      irq_is(4'd0, "R1 no irq after reset");
      // R2 interval match
      wr(3'd1, 3'd0, 32'h0000_0A00);
      ticks(4);
      irq_is(4'd0, "R2 no irq before limit");
      ticks(1);
      irq_is(4'b0001, "R2 irq at limit");
      rd(3'd1, 3'd1, 32'h8000_0000, "R2 reached bit and count wrap");
      // R3 read-clear, keep-count limit write
      rd(3'd1, 3'd0, 32'h0000_0A00, "R3 limit readback");
      irq_is(4'd0, "R3 irq cleared by limit read");
      rd(3'd1, 3'd1, 32'h0000_0000, "R3 reached cleared by limit read");
      ticks(3);
      wr(3'd1, 3'd2, 32'h0000_1000);
      rd(3'd1, 3'd1, 32'h0000_0600, "R3 keep-count write leaves count");
      // R12 free-run timer 2 after 8 ticks
      rd(3'd3, 3'd1, 32'h0000_1000, "R12 free-run count, no reached");
      // R5 switch with pending irq
      ticks(5);
      irq_is(4'b0001, "R2 irq at new limit");
      wr(3'd0, 3'd4, 32'hFFFF_FFF1);
      irq_is(4'd0, "R5 irq lowered on entering user mode");
      rd(3'd0, 3'd4, 32'h0000_0001, "R4 upper mode bits ignored");
      rd(3'd1, 3'd3, 32'd0, "R5 stopped on entering user mode");
      rd(3'd1, 3'd0, 32'd0, "R5 count and reached cleared");
      // R4 processor window mode write ignored
      wr(3'd2, 3'd4, 32'h0000_000F);
      rd(3'd0, 3'd4, 32'h0000_0001, "R4 processor window mode write ignored");
      // R7 R6 user halves
      wr(3'd1, 3'd0, 32'h0000_0012);
      wr(3'd1, 3'd1, 32'h0000_0600);
      rd(3'd1, 3'd1, 32'h0000_0600, "R7 lower half written");
      rd(3'd1, 3'd0, 32'h0000_0012, "R6 upper half read");
      // R8 start/stop
      ticks(3);
      rd(3'd1, 3'd1, 32'h0000_0600, "R8 stopped counter holds");
      wr(3'd1, 3'd3, 32'd1);
      ticks(4);
      rd(3'd1, 3'd1, 32'h0000_0E00, "R8 running counter advances");
      wr(3'd1, 3'd3, 32'd1);
      rd(3'd1, 3'd3, 32'd1, "R8 repeated start no effect");
      rd(3'd1, 3'd1, 32'h0000_0E00, "R8 repeated start keeps count");
      wr(3'd1, 3'd3, 32'd0);
      ticks(2);
      rd(3'd1, 3'd1, 32'h0000_0E00, "R8 stop holds count");
      wr(3'd1, 3'd1, 32'h0000_03FF);
      rd(3'd1, 3'd1, 32'h0000_0200, "R6 low nine bits read zero");
      // R13 wrap at 54-bit maximum
      wr(3'd1, 3'd0, 32'h7FFF_FFFF);
      wr(3'd1, 3'd1, 32'hFFFF_FE00);
      wr(3'd1, 3'd3, 32'd1);
      ticks(1);
      rd(3'd1, 3'd0, 32'h8000_0000, "R13 wrap sets reached");
      rd(3'd1, 3'd1, 32'h0000_0000, "R13 wrap clears low half");
      irq_is(4'd0, "R9 no irq on user wrap");
      wr(3'd1, 3'd3, 32'd0);
      wr(3'd1, 3'd1, 32'h0000_0400);
      rd(3'd1, 3'd0, 32'h0000_0000, "R7 write clears reached");
      // R8 status write ignored in interval mode
      wr(3'd3, 3'd3, 32'd0);
      rd(3'd3, 3'd3, 32'd1, "R8 interval status write ignored");
      // R10 back to interval mode
      wr(3'd0, 3'd4, 32'd0);
      rd(3'd1, 3'd3, 32'd1, "R10 running after leaving user mode");
      rd(3'd1, 3'd1, 32'd0, "R10 count restarts at zero");
      rd(3'd1, 3'd0, 32'h0000_1000, "R10 limit kept");
      ticks(8);
      irq_is(4'b0001, "R10 interval irq after restart");
      // R11 zero reads
      rd(3'd0, 3'd3, 32'd0, "R11 system window status reads zero");
      rd(3'd5, 3'd0, 32'd0, "R11 unused window reads zero");
      step(0, 0, 0, 3'd0, 3'd0, 32'd0);
      @(negedge clk);
      finish_run();
   end
endmodule